// File: doc/BRIEF.md
# Hit-Under-Miss Load Miss Tracker

This block is the control side of a non-blocking data cache port. A load that misses does not hold up the pipeline. The tracker records the miss in one of a small number of miss slots, together with the register the load will write. The refill engine is told which slot the miss took. Later loads that hit are served without delay, and instructions that use other registers keep issuing while misses are outstanding.

Each issuing instruction presents two source registers and one destination register. If any of them names a register that a pending miss will write, the tracker raises a stall. This covers read-after-write and write-after-write hazards against late load data. A stall is also raised when a load misses and every slot is already occupied. A refill-done pulse carries a slot number. It frees that slot and releases its register in the same cycle. A miss arriving in that same cycle may take the freed slot at once.

Top module: `miss_tracker`

## Requirements
- R1: After reset no slot is pending: an issuing instruction is never stalled on a register, and the first load miss takes slot 0.
- R2: A load miss (ld_valid_i=1, ld_hit_i=0) with a free slot sets miss_take_o=1 in the same cycle and gives miss_slot_o as the lowest-numbered free slot. The slot holds ld_dst_i from the next cycle on.
- R3: A load with ld_hit_i=1 never takes a slot, leaves miss_take_o at 0, and does not by itself raise stall_o.
- R4: While iss_valid_i=1, stall_o is 1 whenever iss_src_a_i or iss_src_b_i equals the register of a pending slot.
- R5: While iss_valid_i=1, stall_o is 1 whenever iss_dst_i equals the register of a pending slot.
- R6: An issuing instruction whose three registers match no pending slot does not raise stall_o, even with misses outstanding.
- R7: A load miss while all slots are pending and no refill-done arrives raises stall_o and leaves miss_take_o at 0. No slot is written, so its register never causes a dependency stall.
- R8: A refill-done (fill_valid_i=1, fill_slot_i=n) frees slot n in the same cycle. An instruction issuing in that cycle is not stalled on that slot's register.
- R9: When all slots are pending and a refill-done coincides with a load miss, the miss takes the freed slot (miss_slot_o=fill_slot_i) and stall_o is not raised by the miss.
- R10: A refill-done naming a slot number not below the slot count, or a slot that is not pending, changes no slot.
- R11: With iss_valid_i=0 no dependency stall is raised, whatever the register inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | A load is looking up the cache this cycle |
| ld_hit_i | input | 1 | The load hit (1) or missed (0) |
| ld_dst_i | input | REG_W | Destination register of the load |
| fill_valid_i | input | 1 | Refill-done pulse |
| fill_slot_i | input | SLOT_W | Slot whose refill completed |
| iss_valid_i | input | 1 | An instruction is issuing |
| iss_src_a_i | input | REG_W | First source register of the issuing instruction |
| iss_src_b_i | input | REG_W | Second source register of the issuing instruction |
| iss_dst_i | input | REG_W | Destination register of the issuing instruction |
| miss_take_o | output | 1 | The current miss was given a slot |
| miss_slot_o | output | SLOT_W | Slot given to the current miss |
| stall_o | output | 1 | Hold the pipeline this cycle |

## Verification
The hardest case to reach is a full tracker that gets a refill-done and a new miss in the same cycle. It needs three misses in a row with no refill, followed by one cycle in which both pulses are driven together. The directed part of the bench builds this sequence on purpose. It first checks the blocked fourth miss, then makes the refill and the miss coincide and checks that the freed slot is reused. A random phase follows that draws registers from a narrow range, so that matches, full slots and coincident refills recur often. Every cycle is compared against a behavioural model of the slots.

// File: rtl/miss_tracker_pkg.sv
package miss_tracker_pkg;
  localparam int unsigned MT_SLOTS = 3;
  localparam int unsigned MT_REG_W = 4;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mt_slot.sv
module mt_slot #(
  parameter int unsigned REG_W  = 4,
  parameter int unsigned SLOT_W = 2,
  parameter int unsigned ID     = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_valid_i,
  input  logic [SLOT_W-1:0] fill_slot_i,
  input  logic              alloc_i,
  input  logic [REG_W-1:0]  alloc_dst_i,
  input  logic              iss_valid_i,
  input  logic [REG_W-1:0]  iss_src_a_i,
  input  logic [REG_W-1:0]  iss_src_b_i,
  input  logic [REG_W-1:0]  iss_dst_i,
  output logic              vld_o,
  output logic              live_o,
  output logic              hit_o
);
  logic             vld_q;
  logic [REG_W-1:0] dst_q;
  logic             clr;

  assign clr = fill_valid_i && (fill_slot_i == SLOT_W'(ID));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dst_q <= '0;
    end else if (alloc_i) begin
      vld_q <= 1'b1;
      dst_q <= alloc_dst_i;
    end else if (clr) begin
      vld_q <= 1'b0;
    end
  end

  // refill releases the register in the cycle it arrives
  assign vld_o  = vld_q;
  assign live_o = vld_q && !clr;
  assign hit_o  = live_o && iss_valid_i &&
                  ((dst_q == iss_src_a_i) || (dst_q == iss_src_b_i) || (dst_q == iss_dst_i));

  a_r2_alloc_free_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !live_o);
  a_r8_fill_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr && !alloc_i |=> !vld_q);
  a_r2_alloc_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> vld_q && (dst_q == $past(alloc_dst_i)));
endmodule

// File: rtl/mt_pick.sv
module mt_pick #(
  parameter int unsigned N     = 3,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     free_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     oh_o
);
  // lowest index wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    oh_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) begin
        any_o    = 1'b1;
        idx_o    = IDX_W'(i);
        oh_o     = '0;
        oh_o[i]  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/miss_tracker.sv
module miss_tracker
  import miss_tracker_pkg::*;
#(
  parameter int unsigned SLOTS  = MT_SLOTS,
  parameter int unsigned REG_W  = MT_REG_W,
  parameter int unsigned SLOT_W = idx_bits(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic              ld_hit_i,
  input  logic [REG_W-1:0]  ld_dst_i,
  input  logic              fill_valid_i,
  input  logic [SLOT_W-1:0] fill_slot_i,
  input  logic              iss_valid_i,
  input  logic [REG_W-1:0]  iss_src_a_i,
  input  logic [REG_W-1:0]  iss_src_b_i,
  input  logic [REG_W-1:0]  iss_dst_i,
  output logic              miss_take_o,
  output logic [SLOT_W-1:0] miss_slot_o,
  output logic              stall_o
);
  logic [SLOTS-1:0]  vld, live, hit, pick_oh, alloc_oh;
  logic              miss_req, any_free, full_stall, dep_stall;
  logic [SLOT_W-1:0] pick_idx;

  assign miss_req = ld_valid_i && !ld_hit_i;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    mt_slot #(.REG_W(REG_W), .SLOT_W(SLOT_W), .ID(g)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fill_valid_i(fill_valid_i),
      .fill_slot_i (fill_slot_i),
      .alloc_i     (alloc_oh[g]),
      .alloc_dst_i (ld_dst_i),
      .iss_valid_i (iss_valid_i),
      .iss_src_a_i (iss_src_a_i),
      .iss_src_b_i (iss_src_b_i),
      .iss_dst_i   (iss_dst_i),
      .vld_o       (vld[g]),
      .live_o      (live[g]),
      .hit_o       (hit[g])
    );
  end

  mt_pick #(.N(SLOTS), .IDX_W(SLOT_W)) u_pick (
    .free_i(~live),
    .any_o (any_free),
    .idx_o (pick_idx),
    .oh_o  (pick_oh)
  );

  assign miss_take_o = miss_req && any_free;
  assign alloc_oh    = pick_oh & {SLOTS{miss_take_o}};
  assign miss_slot_o = pick_idx;
  assign full_stall  = miss_req && !any_free;
  assign dep_stall   = |hit;
  assign stall_o     = full_stall || dep_stall;

  a_r7_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_req && (&vld) && !fill_valid_i |-> stall_o && !miss_take_o);
  a_r9_fill_reuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_req && (&vld) && fill_valid_i && (int'(fill_slot_i) < SLOTS)
      |-> miss_take_o && (miss_slot_o == fill_slot_i));
  a_r3_hit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i && ld_hit_i |-> !miss_take_o);
  a_r11_idle_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iss_valid_i && !miss_req |-> !stall_o);
  a_r10_bad_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i && (int'(fill_slot_i) >= SLOTS) && !miss_take_o |=> vld == $past(vld));
  a_r2_one_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(alloc_oh));
endmodule

// File: tb/miss_tracker_test.sv
module miss_tracker_test;
  localparam int NS = 3;
  localparam int RW = 4;
  localparam int SW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_v = 0, ld_h = 0, fill_v = 0, iss_v = 0;
  logic [RW-1:0] ld_d = 0, src_a = 0, src_b = 0, dst = 0;
  logic [SW-1:0] fill_s = 0;
  logic take, stall;
  logic [SW-1:0] slot;

  int total = 0, bad = 0;
  bit m_vld[NS];
  int m_dst[NS];

  always #10 clk = ~clk;

  miss_tracker uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_valid_i(ld_v), .ld_hit_i(ld_h), .ld_dst_i(ld_d),
    .fill_valid_i(fill_v), .fill_slot_i(fill_s),
    .iss_valid_i(iss_v), .iss_src_a_i(src_a), .iss_src_b_i(src_b), .iss_dst_i(dst),
    .miss_take_o(take), .miss_slot_o(slot), .stall_o(stall)
  );

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit lv, bit lh, int ldd, bit fv, int fs,
                      bit iv, int a, int b, int d);
    bit live[NS];
    bit e_take, e_stall, dep;
    int e_slot;
    @(negedge clk);
    ld_v = lv; ld_h = lh; ld_d = RW'(ldd);
    fill_v = fv; fill_s = SW'(fs);
    iss_v = iv; src_a = RW'(a); src_b = RW'(b); dst = RW'(d);
    #2;
    e_slot = -1;
    dep = 0;
    for (int i = 0; i < NS; i++) begin
      live[i] = m_vld[i] && !(fv && fs == i);
      if (!live[i] && e_slot < 0) e_slot = i;
      if (iv && live[i] && (m_dst[i] == a || m_dst[i] == b || m_dst[i] == d)) dep = 1;
    end
    e_take  = lv && !lh && (e_slot >= 0);
    e_stall = (lv && !lh && e_slot < 0) || dep;
    chk(tag, "stall", int'(stall), int'(e_stall));
    chk(tag, "take", int'(take), int'(e_take));
    if (e_take) chk(tag, "slot", int'(slot), e_slot);
    @(posedge clk);
    for (int i = 0; i < NS; i++) if (fv && fs == i) m_vld[i] = 0;
    if (e_take) begin
      m_vld[e_slot] = 1;
      m_dst[e_slot] = ldd;
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) begin m_vld[i] = 0; m_dst[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: empty after reset
    step("R1", 0,0,0, 0,0, 1, 5,6,7);
    step("R1 R2", 1,0,3, 0,0, 0, 0,0,0);
    step("R6", 0,0,0, 0,0, 1, 1,2,4);
    step("R4", 0,0,0, 0,0, 1, 3,2,4);
    step("R4", 0,0,0, 0,0, 1, 1,3,4);
    step("R5", 0,0,0, 0,0, 1, 1,2,3);
    step("R3", 1,1,7, 0,0, 1, 7,7,7);
    step("R2", 1,0,5, 0,0, 0, 0,0,0);
    step("R2", 1,0,6, 0,0, 1, 1,2,4);
    step("R7", 1,0,8, 0,0, 0, 0,0,0);
    step("R7", 0,0,0, 0,0, 1, 8,8,8);
    step("R9", 1,0,9, 1,1, 0, 0,0,0);
    step("R4 R9", 0,0,0, 0,0, 1, 9,0,0);
    step("R6 R9", 0,0,0, 0,0, 1, 5,0,1);
    step("R8", 0,0,0, 1,0, 1, 3,1,2);
    step("R8", 0,0,0, 0,0, 1, 3,1,2);
    step("R10", 0,0,0, 1,3, 1, 6,1,2);
    step("R10", 0,0,0, 1,0, 1, 6,1,2);
    step("R11", 0,0,0, 0,0, 0, 6,9,6);
    step("R2", 1,0,10, 0,0, 0, 0,0,0);
    step("R1 R4", 0,0,0, 0,0, 1, 10,0,0);
    for (int n = 0; n < 400; n++)
      step("R2 R4 R5 R7 R8 R9", $urandom_range(0,1) == 1, $urandom_range(0,2) == 0,
           int'($urandom_range(0,5)), $urandom_range(0,2) == 0, int'($urandom_range(0,3)),
           $urandom_range(0,1) == 1, int'($urandom_range(0,5)),
           int'($urandom_range(0,5)), int'($urandom_range(0,5)));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule